// File: doc/BRIEF.md
# Asynchronous Bus Write-Window Decoder

This block sits between an asynchronous, memory-style parallel bus and a small internal register bank. Its own clock oversamples the bus. The bus strobes are all active low:
- a chip enable selects the internal bank;
- a separate enable selects an external SRAM region;
- a write strobe marks writes;
- an output enable requests read data.

Each strobe, the address and the write data pass through a two-stage synchronizer. The synchronized strobes then build a write window. The window opens on whichever of chip enable or write strobe goes low last. It closes on whichever of the two goes high first. When the window closes, the block writes the data and address it held on the last cycle inside the window into the bank.

For reads, the block drives a data-output enable and the addressed register contents. A low write strobe always turns the read drive off. When the external enable is low and the chip enable is high, the block passes an active-low select through to external memory. If both enables are low together, that is bus contention. Contention sets a sticky error flag and suppresses both selects for as long as it lasts.

Top module: `membus_wr_decoder`

## Requirements
- R1: After reset, `dout_en` is 0, `xsel_n` is 1, `contention_err` is 0, `rdata` is 0, and every bank register reads back as 0.
- R2: A write window is open while `ce_n` and `we_n` are both low, with no contention. When the window closes, the bank register selected by `addr` is loaded with `wdata`. This holds whichever strobe fell first and whichever rose first.
- R3: If `wdata` changes while the window is open, the value present on the last sampled cycle inside the window is committed.
- R4: An address change that arrives together with the closing strobe edge does not redirect the write. The address held inside the window is used, and the new address stays unchanged.
- R5: With `ce_n`=0, `oe_n`=0, `we_n`=1 and `xe_n`=1, `dout_en` is 1 and `rdata` shows the register at `addr`. Whenever `dout_en` is 0, `rdata` is 0.
- R6: A low `we_n` forces `dout_en` to 0, even with `ce_n` and `oe_n` low.
- R7: `xsel_n` is 0 exactly when `xe_n` is 0 and `ce_n` is 1. `dout_en` and an active `xsel_n` are never asserted together.
- R8: `ce_n`=0 and `xe_n`=0 together sets `contention_err`, which stays 1 until reset. While the contention lasts, `dout_en` is 0 and `xsel_n` is 1.
- R9: A write window that is interrupted by contention is discarded. Its target register keeps its old value.
- R10: A low `we_n` while `ce_n` is high writes nothing to the bank.
- R11: Outputs follow a bus input change on the third rising clock edge after it: two synchronizer stages, then one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable for the internal bank, active low |
| xe_n | input | 1 | External region enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW (4) | Register address |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data, 0 when not driving |
| dout_en | output | 1 | Read data output drive enable |
| xsel_n | output | 1 | External memory select, active low |
| contention_err | output | 1 | Sticky bus contention flag |

## Verification
The hardest case to reach from the ports is a write window cut short by contention. A window that is cut short must leave no trace, and it must not reopen into a commit.

To produce this case, the stimulus opens a window on one register and then drops the external enable. It raises the write strobe while the contention still holds, and only then releases the enables. It finally reads the register back and finds its old value.

The window-ordering corners are covered by a sweep over every bank address. The sweep rotates through all four combinations of which strobe falls first and which rises first.

// File: rtl/membus_pkg.sv
package membus_pkg;
    localparam int unsigned ADDR_W_DEF = 4;
    localparam int unsigned DATA_W_DEF = 8;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic ce_n;
        logic xe_n;
        logic we_n;
        logic oe_n;
    } bus_ctrl_t;

    localparam int unsigned CTRL_W = $bits(bus_ctrl_t);
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0] chain_q [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[b] <= {STAGES{RST_VAL}};
            else        chain_q[b] <= {chain_q[b][STAGES-2:0], din[b]};
        end
        assign dout[b] = chain_q[b][STAGES-1];
    end
endmodule

// File: rtl/wr_window.sv
module wr_window #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_ce_n,
    input  logic          s_we_n,
    input  logic          clash,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] s_data,
    output logic          win_active,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);
    typedef struct packed {
        logic          win;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       win_now;

    always_comb begin
        st_d    = st_q;
        win_now = !s_ce_n && !s_we_n && !clash;
        st_d.win = win_now;
        if (win_now) begin
            st_d.addr = s_addr;
            st_d.data = s_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_active  = st_q.win;
    assign commit      = st_q.win && !win_now && !clash;
    assign commit_addr = st_q.addr;
    assign commit_data = st_q.data;
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   cell_q[i] <= '0;
            else if (wr_en && (wr_addr == AW'(i)))        cell_q[i] <= wr_data;
        end
    end

    assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/membus_wr_decoder.sv
module membus_wr_decoder
    import membus_pkg::*;
#(
    parameter int unsigned AW     = ADDR_W_DEF,
    parameter int unsigned DW     = DATA_W_DEF,
    parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          xe_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          dout_en,
    output logic          xsel_n,
    output logic          contention_err
);
    localparam int unsigned BUS_W = AW + DW;

    typedef struct packed {
        logic          dout_en;
        logic          xsel_n;
        logic          err;
        logic [DW-1:0] rdata;
    } out_state_t;

    bus_ctrl_t     ctrl_raw, ctrl_s;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;
    logic          clash;
    logic          win_active_w, commit_w;
    logic [AW-1:0] commit_addr_w;
    logic [DW-1:0] commit_data_w;
    logic [DW-1:0] bank_rd;
    out_state_t    st_d, st_q;

    assign ctrl_raw = '{ce_n: ce_n, xe_n: xe_n, we_n: we_n, oe_n: oe_n};

    bus_sync #(.WIDTH(CTRL_W), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .din(ctrl_raw), .dout(ctrl_s)
    );

    bus_sync #(.WIDTH(BUS_W), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .din({addr, wdata}), .dout({s_addr, s_data})
    );

    assign clash = !ctrl_s.ce_n && !ctrl_s.xe_n;

    wr_window #(.AW(AW), .DW(DW)) u_win (
        .clk(clk), .rst_n(rst_n),
        .s_ce_n(ctrl_s.ce_n), .s_we_n(ctrl_s.we_n), .clash(clash),
        .s_addr(s_addr), .s_data(s_data),
        .win_active(win_active_w), .commit(commit_w),
        .commit_addr(commit_addr_w), .commit_data(commit_data_w)
    );

    reg_bank #(.AW(AW), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_w), .wr_addr(commit_addr_w), .wr_data(commit_data_w),
        .rd_addr(s_addr), .rd_data(bank_rd)
    );

    always_comb begin
        st_d         = st_q;
        st_d.dout_en = !ctrl_s.ce_n && !ctrl_s.oe_n && ctrl_s.we_n && !clash;
        st_d.xsel_n  = !(!ctrl_s.xe_n && ctrl_s.ce_n);
        st_d.err     = st_q.err || clash;
        st_d.rdata   = st_d.dout_en ? bank_rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{dout_en: 1'b0, xsel_n: 1'b1, err: 1'b0, rdata: '0};
        else        st_q <= st_d;
    end

    assign rdata          = st_q.rdata;
    assign dout_en        = st_q.dout_en;
    assign xsel_n         = st_q.xsel_n;
    assign contention_err = st_q.err;
endmodule

// File: rtl/membus_wr_chk.sv
module membus_wr_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] rdata,
    input logic          dout_en,
    input logic          xsel_n,
    input logic          contention_err,
    input logic          win_active,
    input logic          commit
);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(contention_err));

    // R8
    clash_blocks_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(contention_err) |-> (!dout_en && xsel_n));

    // R7
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout_en && !xsel_n));

    // R5
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (rdata == '0));

    // R6
    win_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_active |-> !dout_en);

    // R2
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

bind membus_wr_decoder membus_wr_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rdata(rdata), .dout_en(dout_en),
    .xsel_n(xsel_n), .contention_err(contention_err),
    .win_active(win_active_w), .commit(commit_w)
);

// File: tb/tb_membus_wr_decoder.sv
module tb_membus_wr_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, xe_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic dout_en, xsel_n, contention_err;

    int n_checks = 0;
    int n_fails = 0;
    logic [DW-1:0] mirror [1<<AW];

    always #(CLK_PERIOD/2) clk = ~clk;

    membus_wr_decoder #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .xe_n(xe_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .dout_en(dout_en), .xsel_n(xsel_n), .contention_err(contention_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1'b1; xe_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        cyc(SETTLE);
    endtask

    // variant bit0: 1 = W falls first; bit1: 1 = W rises first
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int variant);
        addr = a; wdata = d;
        cyc(SETTLE);
        if (variant[0]) we_n = 1'b0; else ce_n = 1'b0;
        cyc(SETTLE);
        if (variant[0]) ce_n = 1'b0; else we_n = 1'b0;
        cyc(SETTLE);
        if (variant[1]) we_n = 1'b1; else ce_n = 1'b1;
        cyc(SETTLE);
        idle();
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input string req, input logic [DW-1:0] exp);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        cyc(SETTLE);
        check(req, {31'd0, dout_en}, 32'd1);
        check(req, {24'd0, rdata}, {24'd0, exp});
        idle();
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) mirror[i] = '0;
        cyc(3);
        // R1 reset state
        check("R1", {31'd0, dout_en}, 32'd0);
        check("R1", {31'd0, xsel_n}, 32'd1);
        check("R1", {31'd0, contention_err}, 32'd0);
        check("R1", {24'd0, rdata}, 32'd0);
        rst_n = 1'b1;
        cyc(2);

        // R11 latency: third rising edge after the change
        addr = '0; ce_n = 1'b0; oe_n = 1'b0;
        cyc(2);
        check("R11", {31'd0, dout_en}, 32'd0);
        cyc(1);
        check("R11", {31'd0, dout_en}, 32'd1);
        idle();

        // R1 bank reads zero after reset
        bus_read(4'd9, "R1", 8'h00);

        // R2 sweep every address with all four strobe orderings
        for (int a = 0; a < (1<<AW); a++) begin
            logic [DW-1:0] d;
            d = DW'((a * 37 + 11) & 8'hFF);
            bus_write(AW'(a), d, a % 4);
            mirror[a] = d;
        end
        for (int a = 0; a < (1<<AW); a++) bus_read(AW'(a), "R2", mirror[a]);

        // R3 data changed inside the window: last value wins
        addr = 4'd3; wdata = 8'h11;
        cyc(SETTLE);
        ce_n = 1'b0; we_n = 1'b0;
        cyc(SETTLE);
        wdata = 8'h99;
        cyc(SETTLE);
        we_n = 1'b1;
        cyc(SETTLE);
        idle();
        mirror[3] = 8'h99;
        bus_read(4'd3, "R3", 8'h99);

        // R4 address switched together with the closing edge
        addr = 4'd5; wdata = 8'hA5;
        cyc(SETTLE);
        ce_n = 1'b0; we_n = 1'b0;
        cyc(SETTLE);
        we_n = 1'b1; addr = 4'd6;
        cyc(SETTLE);
        idle();
        mirror[5] = 8'hA5;
        bus_read(4'd5, "R4", 8'hA5);
        bus_read(4'd6, "R4", mirror[6]);

        // R6 low W forces drive off
        addr = 4'd2; wdata = 8'h3C;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        cyc(SETTLE);
        check("R6", {31'd0, dout_en}, 32'd0);
        check("R6", {24'd0, rdata}, 32'd0);
        idle();
        mirror[2] = 8'h3C;

        // R10 W low with E high writes nothing
        addr = 4'd8; wdata = 8'hEE;
        we_n = 1'b0;
        cyc(SETTLE);
        idle();
        bus_read(4'd8, "R10", mirror[8]);

        // R7 external select pass-through
        xe_n = 1'b0;
        cyc(SETTLE);
        check("R7", {31'd0, xsel_n}, 32'd0);
        check("R7", {31'd0, dout_en}, 32'd0);
        idle();
        check("R7", {31'd0, xsel_n}, 32'd1);

        // R9 / R8 window interrupted by contention
        check("R8", {31'd0, contention_err}, 32'd0);
        addr = 4'd7; wdata = 8'h5A;
        cyc(SETTLE);
        ce_n = 1'b0; we_n = 1'b0;
        cyc(SETTLE);
        xe_n = 1'b0;
        cyc(SETTLE);
        check("R8", {31'd0, contention_err}, 32'd1);
        check("R8", {31'd0, xsel_n}, 32'd1);
        check("R8", {31'd0, dout_en}, 32'd0);
        we_n = 1'b1;
        cyc(SETTLE);
        idle();
        check("R8", {31'd0, contention_err}, 32'd1);
        bus_read(4'd7, "R9", mirror[7]);

        // R5 / R7 / R8 sweep of all strobe combinations
        addr = 4'd15; wdata = mirror[15];
        for (int c = 0; c < 16; c++) begin
            logic e, x, w, g;
            {e, x, w, g} = 4'(c);
            ce_n = e; xe_n = x; we_n = w; oe_n = g;
            cyc(SETTLE);
            check("R5", {31'd0, dout_en}, {31'd0, (!e && !g && w && x)});
            check("R7", {31'd0, xsel_n}, {31'd0, !(!x && e)});
        end
        idle();
        bus_read(4'd15, "R5", mirror[15]);

        // R1 / R8 reset clears flag and bank
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(2);
        check("R8", {31'd0, contention_err}, 32'd0);
        bus_read(4'd3, "R1", 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule